// File: doc/BRIEF.md
# Watch-State Power Sequencer

This controller decides when a core running at full speed drops into a low-power watch state. It also decides how the core returns from that state. A sleep strobe starts watch entry only if three configuration bits agree: standby chosen, direct transition off, and the watchdog clocked from its secondary prescaler. Even then, entry happens only while the core is at full speed. In the watch state, the core clock and the general peripheral clock are gated off. The infrared-receiver clock and the secondary-watchdog clock stay on.

Wakeup combines several sources:
- NMI, which no mask can block.
- The watchdog overflow.
- Three 16-bit groups of external lines (interrupt request, keyboard, wakeup event), each line with its own enable bit.
- A PS/2 and an infrared interrupt, each with an enable.

A global CPU mask blocks every source except NMI. A qualified wakeup leads either to medium speed, with the interrupt-start pulse given at once, or to full speed. For full speed, a settling count of 2^(BASE_EXP+n) cycles runs first, where n is a 3-bit select. The reset pin overrides everything. While the pin is low, all clocks run and the mode shows reset. When the pin is released, a reset-exception pulse is issued.

Top module: `watch_ctl`

## Requirements
- R1: A sleep strobe taken at full speed (mode 00, not settling) with standby_sel=1, direct_xfer=0 and wdt_clk_sel=1 puts the block in watch (mode 10) on the next cycle.
- R2: A sleep strobe with any other combination of those three bits, or taken in medium speed (mode 01), leaves the mode unchanged.
- R3: In watch, cpu_clk_en and periph_clk_en are 0 and ir_clk_en and wdt_clk_en are 1; in every other mode all four are 1.
- R4: Bit i of irq_in, key_in or wue_in wakes the watch state only when bit i of the matching enable vector is 1 and cpu_mask is 0.
- R5: ps2_irq and ir_irq wake only with their enables at 1; wdt_ovf needs no enable; cpu_mask=1 blocks all of these.
- R6: nmi wakes the watch state regardless of cpu_mask.
- R7: A wakeup with med_sel=1 moves to medium speed (mode 01) on the next cycle, with irq_start high for exactly that one cycle.
- R8: A wakeup with med_sel=0 starts settling (mode reads 00, all clocks on); irq_start pulses for one cycle 2^(BASE_EXP+settle_sel) cycles after the wakeup edge.
- R9: Wake inputs during settling do not restart or shorten the count.
- R10: reset_pin_n low forces mode 11 with all clocks on from the next cycle. After release, the next cycle gives mode 00 with rst_exc_start high for one cycle.
- R11: After rst_n, mode is 00, all clock enables are 1 and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset of the controller |
| sleep_req | input | 1 | Sleep strobe from the CPU |
| standby_sel | input | 1 | Standby-select control bit |
| direct_xfer | input | 1 | Direct-transition control bit |
| wdt_clk_sel | input | 1 | Watchdog secondary prescaler select |
| med_sel | input | 1 | Exit target: 1 medium speed, 0 full speed |
| settle_sel | input | 3 | Settling count exponent offset n |
| nmi | input | 1 | Non-maskable interrupt |
| wdt_ovf | input | 1 | Secondary watchdog overflow interrupt |
| irq_in | input | SRC_W | External interrupt request lines |
| irq_en | input | SRC_W | Per-line enables for irq_in |
| key_in | input | SRC_W | Keyboard inputs |
| key_en | input | SRC_W | Per-line enables for key_in |
| wue_in | input | SRC_W | Wakeup-event inputs |
| wue_en | input | SRC_W | Per-line enables for wue_in |
| ps2_irq | input | 1 | PS/2 interrupt |
| ps2_en | input | 1 | PS/2 interrupt enable |
| ir_irq | input | 1 | Infrared-receiver interrupt |
| ir_en | input | 1 | Infrared-receiver interrupt enable |
| cpu_mask | input | 1 | CPU global interrupt mask |
| reset_pin_n | input | 1 | Chip reset pin, active low |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | General peripheral clock gate enable |
| ir_clk_en | output | 1 | Infrared-receiver clock gate enable |
| wdt_clk_en | output | 1 | Secondary watchdog clock gate enable |
| mode | output | 2 | 00 full speed, 01 medium, 10 watch, 11 reset held |
| irq_start | output | 1 | One-cycle interrupt exception start |
| rst_exc_start | output | 1 | One-cycle reset exception start |

## Verification
Entry is tried with all eight settings of the three control bits. This separates the single qualifying setting from every near miss. Each of the 48 grouped wake lines is driven once with its own enable set and once with only a neighbouring enable set. This shows that qualification is per bit and not a group OR. The settling count is swept over all eight select values on a small BASE_EXP, so any off-by-one or wrong exponent shows up as a cycle-count mismatch. Masked, unmasked, NMI and mid-settle wake patterns separate the mask path and the count-restart behaviour.

// File: rtl/watch_ctl.sv
module watch_ctl #(
  parameter int SRC_W    = 16,
  parameter int BASE_EXP = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             standby_sel,
  input  logic             direct_xfer,
  input  logic             wdt_clk_sel,
  input  logic             med_sel,
  input  logic [2:0]       settle_sel,
  input  logic             nmi,
  input  logic             wdt_ovf,
  input  logic [SRC_W-1:0] irq_in,
  input  logic [SRC_W-1:0] irq_en,
  input  logic [SRC_W-1:0] key_in,
  input  logic [SRC_W-1:0] key_en,
  input  logic [SRC_W-1:0] wue_in,
  input  logic [SRC_W-1:0] wue_en,
  input  logic             ps2_irq,
  input  logic             ps2_en,
  input  logic             ir_irq,
  input  logic             ir_en,
  input  logic             cpu_mask,
  input  logic             reset_pin_n,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             ir_clk_en,
  output logic             wdt_clk_en,
  output logic [1:0]       mode,
  output logic             irq_start,
  output logic             rst_exc_start
);
  localparam int CW = BASE_EXP + 8;

  typedef enum logic [2:0] {S_HIGH, S_MED, S_WATCH, S_SETTLE, S_RST} st_t;
  st_t state;
  logic [CW-1:0] cnt;

  wire maskable = wdt_ovf | (|(irq_in & irq_en)) | (|(key_in & key_en))
                | (|(wue_in & wue_en)) | (ps2_irq & ps2_en) | (ir_irq & ir_en);
  wire wake     = nmi | (~cpu_mask & maskable);
  wire enter    = sleep_req & standby_sel & ~direct_xfer & wdt_clk_sel;
  wire settling = (state == S_SETTLE);
  wire [CW-1:0] one  = CW'(1);
  wire [CW-1:0] load = (one << (BASE_EXP + 32'(settle_sel))) - one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_HIGH;
      cnt           <= '0;
      irq_start     <= 1'b0;
      rst_exc_start <= 1'b0;
    end else begin
      irq_start     <= 1'b0;
      rst_exc_start <= 1'b0;
      if (!reset_pin_n) state <= S_RST;
      else begin
        case (state)
          S_HIGH:  if (enter) state <= S_WATCH;
          S_WATCH: if (wake) begin
            if (med_sel) begin
              state     <= S_MED;
              irq_start <= 1'b1;
            end else begin
              state <= S_SETTLE;
              cnt   <= load;
            end
          end
          S_SETTLE: if (cnt == '0) begin
            state     <= S_HIGH;
            irq_start <= 1'b1;
          end else cnt <= cnt - one;
          S_RST: begin
            state         <= S_HIGH;
            rst_exc_start <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign cpu_clk_en    = (state != S_WATCH);
  assign periph_clk_en = (state != S_WATCH);
  assign ir_clk_en     = 1'b1;
  assign wdt_clk_en    = 1'b1;

  always_comb begin
    case (state)
      S_MED:   mode = 2'b01;
      S_WATCH: mode = 2'b10;
      S_RST:   mode = 2'b11;
      default: mode = 2'b00;
    endcase
  end
endmodule

// File: rtl/watch_ctl_chk.sv
module watch_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic       standby_sel,
  input logic       direct_xfer,
  input logic       wdt_clk_sel,
  input logic       nmi,
  input logic       cpu_mask,
  input logic       reset_pin_n,
  input logic       cpu_clk_en,
  input logic       periph_clk_en,
  input logic       ir_clk_en,
  input logic       wdt_clk_en,
  input logic [1:0] mode,
  input logic       irq_start,
  input logic       rst_exc_start,
  input logic       settling
);
  p_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && standby_sel && !direct_xfer && wdt_clk_sel && mode == 2'b00 && !settling && reset_pin_n)
    |=> mode == 2'b10);

  p_noentry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode == 2'b10) |-> $past(sleep_req && standby_sel && !direct_xfer && wdt_clk_sel && mode == 2'b00));

  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (!cpu_clk_en && !periph_clk_en && ir_clk_en && wdt_clk_en));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && cpu_mask && !nmi && reset_pin_n) |=> mode == 2'b10);

  p_nmi_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && nmi && reset_pin_n) |=> mode != 2'b10);

  p_med_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode == 2'b01) |-> irq_start);

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_start |=> !irq_start);

  p_settle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    settling |-> (mode == 2'b00 && !irq_start && cpu_clk_en));

  p_reset_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_pin_n |=> (mode == 2'b11 && cpu_clk_en && periph_clk_en));

  p_rst_exc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_exc_start |-> ($past(mode) == 2'b11 && mode == 2'b00));
endmodule

bind watch_ctl watch_ctl_chk chk (.*);

// File: tb/sim_watch_ctl.sv
`timescale 1ns/1ps
module sim_watch_ctl;
  localparam int W = 16;
  localparam int BE = 2;

  logic clk = 0, rst_n = 0;
  logic sleep_req = 0, standby_sel = 0, direct_xfer = 0, wdt_clk_sel = 0, med_sel = 0;
  logic [2:0] settle_sel = 0;
  logic nmi = 0, wdt_ovf = 0;
  logic [W-1:0] irq_in = 0, irq_en = 0, key_in = 0, key_en = 0, wue_in = 0, wue_en = 0;
  logic ps2_irq = 0, ps2_en = 0, ir_irq = 0, ir_en = 0, cpu_mask = 0, reset_pin_n = 1;
  logic cpu_clk_en, periph_clk_en, ir_clk_en, wdt_clk_en, irq_start, rst_exc_start;
  logic [1:0] mode;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  watch_ctl #(.SRC_W(W), .BASE_EXP(BE)) u0 (.*);

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_src;
    nmi = 0; wdt_ovf = 0; irq_in = 0; irq_en = 0; key_in = 0; key_en = 0;
    wue_in = 0; wue_en = 0; ps2_irq = 0; ps2_en = 0; ir_irq = 0; ir_en = 0; cpu_mask = 0;
  endtask

  task automatic go_high;
    clr_src; reset_pin_n = 0; tick; reset_pin_n = 1; tick;
  endtask

  task automatic go_watch;
    standby_sel = 1; direct_xfer = 0; wdt_clk_sel = 1; sleep_req = 1; tick; sleep_req = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) tick;
    rst_n = 1; tick;
    // R11 reset state
    chk(mode == 2'b00 && cpu_clk_en && periph_clk_en && ir_clk_en && wdt_clk_en
        && !irq_start && !rst_exc_start, "R11 reset state", mode, 0);

    // R1 / R2 sweep of the three control bits
    for (int c = 0; c < 8; c++) begin
      go_high;
      {standby_sel, direct_xfer, wdt_clk_sel} = 3'(c);
      sleep_req = 1; tick; sleep_req = 0;
      chk(mode == ((c == 5) ? 2'b10 : 2'b00), (c == 5) ? "R1 entry" : "R2 no entry",
          mode, (c == 5) ? 2 : 0);
      if (c == 5) begin
        // R3 gating in watch
        chk(!cpu_clk_en && !periph_clk_en && ir_clk_en && wdt_clk_en, "R3 watch gating",
            {cpu_clk_en, periph_clk_en, ir_clk_en, wdt_clk_en}, 3);
      end else begin
        chk(cpu_clk_en && periph_clk_en, "R3 clocks on outside watch",
            {cpu_clk_en, periph_clk_en}, 3);
      end
    end

    // R7 medium exit, then R2 sleep in medium ignored
    go_high; go_watch; med_sel = 1; nmi = 1; tick; nmi = 0;
    chk(mode == 2'b01 && irq_start, "R7 medium exit", {mode, irq_start}, 3);
    tick;
    chk(!irq_start && mode == 2'b01, "R7 single pulse", irq_start, 0);
    go_watch;
    chk(mode == 2'b01, "R2 sleep in medium ignored", mode, 1);
    med_sel = 0;

    // R4 per-bit qualification, three groups
    for (int g = 0; g < 3; g++) begin
      for (int i = 0; i < W; i++) begin
        for (int m = 0; m < 2; m++) begin
          logic [W-1:0] s, e;
          go_high; go_watch;
          s = W'(1) << i;
          e = W'(1) << ((i + m) % W);
          case (g)
            0: begin irq_in = s; irq_en = e; end
            1: begin key_in = s; key_en = e; end
            default: begin wue_in = s; wue_en = e; end
          endcase
          tick;
          chk(mode == ((m == 0) ? 2'b00 : 2'b10), "R4 per-bit enable", mode, (m == 0) ? 0 : 2);
          clr_src;
        end
      end
    end

    // R5 peripheral enables and mask
    go_high; go_watch; cpu_mask = 1; irq_in = 1; irq_en = 1; wdt_ovf = 1;
    ps2_irq = 1; ps2_en = 1; ir_irq = 1; ir_en = 1; tick;
    chk(mode == 2'b10, "R5 mask blocks", mode, 2);
    clr_src; ps2_irq = 1; tick;
    chk(mode == 2'b10, "R5 ps2 disabled", mode, 2);
    ir_irq = 1; tick;
    chk(mode == 2'b10, "R5 ir disabled", mode, 2);
    ps2_en = 1; tick;
    chk(mode == 2'b00, "R5 ps2 enabled wakes", mode, 0);
    go_high; go_watch; ir_irq = 1; ir_en = 1; tick;
    chk(mode == 2'b00, "R5 ir enabled wakes", mode, 0);
    go_high; go_watch; wdt_ovf = 1; tick;
    chk(mode == 2'b00, "R5 wdt overflow wakes", mode, 0);

    // R6 NMI ignores mask
    go_high; go_watch; cpu_mask = 1; nmi = 1; tick;
    chk(mode == 2'b00, "R6 nmi through mask", mode, 0);

    // R8 settling sweep
    for (int n = 0; n < 8; n++) begin
      go_high; go_watch; settle_sel = 3'(n); nmi = 1; tick; nmi = 0;
      chk(mode == 2'b00 && cpu_clk_en && !irq_start, "R8 settling mode", mode, 0);
      cnt = 0;
      while (!irq_start && cnt < 5000) begin tick; cnt++; end
      chk(cnt == (1 << (BE + n)), "R8 settle length", cnt, 1 << (BE + n));
      tick;
      chk(!irq_start && mode == 2'b00, "R8 single pulse", irq_start, 0);
    end

    // R9 wake during settling ignored
    go_high; go_watch; settle_sel = 3; nmi = 1; tick; nmi = 0;
    cnt = 0;
    while (!irq_start && cnt < 5000) begin
      if (cnt == 10) begin nmi = 1; irq_in = 1; irq_en = 1; end
      if (cnt == 11) clr_src;
      tick; cnt++;
    end
    chk(cnt == (1 << (BE + 3)), "R9 no restart", cnt, 1 << (BE + 3));

    // R10 reset pin
    go_high; go_watch; reset_pin_n = 0; tick;
    chk(mode == 2'b11 && cpu_clk_en && periph_clk_en, "R10 reset held", mode, 3);
    tick; tick;
    chk(!rst_exc_start && mode == 2'b11, "R10 no exception while low", rst_exc_start, 0);
    reset_pin_n = 1; tick;
    chk(mode == 2'b00 && rst_exc_start, "R10 release", {mode, rst_exc_start}, 1);
    tick;
    chk(!rst_exc_start, "R10 single pulse", rst_exc_start, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule